// File: doc/BRIEF.md
# MHz-Step Feedback Divider

This block is the loadable feedback divider of a frequency synthesizer loop. It takes a squared pulse train from the loop mixer and a binary megahertz step setting. It reduces the setting modulo 40 to get a start count R. It then counts falling edges of the pulse train from R upward. The edge that would bring the count to 47 reloads R and emits a one-clock pulse toward the phase comparator. The division ratio is therefore 47 − R, which lies between 8 and 47 and repeats every 40 steps of the setting.

The pulse train is asynchronous to the system clock. It passes through a two-flop synchronizer and a falling-edge detector, which produce one count enable per input fall. A new setting is taken only at a reload, so a period in progress is never cut short. Reset is asynchronous and active-low, with a synchronized release. In the first clock after reset releases, the counter loads R from the setting present at that moment.

Top module: `mhz_step_divider`

## Requirements
- R1: The start count R equals the step setting modulo 40, and `div_ratio` reports 47 − R (binary, from 8 to 47) for the period now running.
- R2: Only a high-to-low transition of `pulse_in` advances the count. Rising edges and a level held steady have no effect.
- R3: Exactly 47 − R falling edges of `pulse_in` occur per `div_pulse`. The counter holds R through 46, and the edge that would reach 47 reloads R instead.
- R4: `div_pulse` is high for exactly one clock cycle per reload.
- R5: A change of `step_set` has no effect on the running period or on `div_ratio` until the next reload. The next period then uses the new ratio.
- R6: While reset is asserted, `div_pulse` is low. After release, the first period is a full 47 − R edges for the setting applied at release.
- R7: Settings that differ by a multiple of 40 give the same ratio. Every value of the 10-bit input up to 1023 is accepted (for example, 999 gives ratio 8 and 1023 gives ratio 24).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the pulse train |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_set | input | 10 | Megahertz step setting S, binary |
| pulse_in | input | 1 | Squared mixer difference pulse train, asynchronous |
| div_pulse | output | 1 | One-cycle pulse per completed division |
| div_ratio | output | 6 | Division ratio 47 − R of the running period |

## Verification
The bench runs the two ends of the ratio range (S = 0 gives 47 and S = 39 gives 8). It also runs settings above 40 and the out-of-range values 999 and 1023. A wrong modulo reduction would show up there as a wrong edge count per pulse. The bench changes the setting partway through a period. A design that applied the new R at once would shorten that period or update `div_ratio` early. The bench also holds the input high for a long time and resets during a period in progress. These cases catch a counter that advances on levels or rising edges, and one that comes out of reset off by one edge.

// File: rtl/wdiv_pkg.sv
package wdiv_pkg;
  localparam int SET_W_DEF   = 10;
  localparam int MOD_BASE_DEF = 40;
  localparam int TERM_DEF    = 47;

  typedef enum logic {
    PH_PRIME = 1'b0,
    PH_RUN   = 1'b1
  } div_phase_e;
endpackage

// File: rtl/wdiv_edge_sync.sv
module wdiv_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic fall_o
);
  logic meta_q, stab_q, hist_q;
  logic meta_d, stab_d, hist_d;

  always_comb begin
    meta_d = async_i;
    stab_d = meta_q;
    hist_d = stab_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      stab_q <= 1'b1;
      hist_q <= 1'b1;
    end else begin
      meta_q <= meta_d;
      stab_q <= stab_d;
      hist_q <= hist_d;
    end
  end

  assign fall_o = hist_q & ~stab_q;

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o); // R2
endmodule

// File: rtl/wdiv_mod_reduce.sv
module wdiv_mod_reduce #(
  parameter int SET_W    = wdiv_pkg::SET_W_DEF,
  parameter int MOD_BASE = wdiv_pkg::MOD_BASE_DEF,
  parameter int REM_W    = $clog2(MOD_BASE)
) (
  input  logic [SET_W-1:0] set_i,
  output logic [REM_W-1:0] rem_o
);
  localparam int KMAX = SET_W - $clog2(MOD_BASE);
  localparam int W    = SET_W + 1;

  logic [W-1:0] part [0:KMAX+1];

  assign part[0] = {1'b0, set_i};

  for (genvar g = 0; g <= KMAX; g++) begin : g_stage
    localparam logic [W-1:0] SUB = W'(MOD_BASE) << (KMAX - g);
    assign part[g+1] = (part[g] >= SUB) ? (part[g] - SUB) : part[g];
  end

  assign rem_o = part[KMAX+1][REM_W-1:0];

  always_comb begin
    AST_REM_RANGE: assert (part[KMAX+1] < W'(MOD_BASE)); // R1
  end
endmodule

// File: rtl/wdiv_counter.sv
module wdiv_counter #(
  parameter int TERM    = wdiv_pkg::TERM_DEF,
  parameter int START_W = 6,
  parameter int CNT_W   = $clog2(TERM + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [START_W-1:0] start_i,
  input  logic               fall_i,
  output logic               pulse_o,
  output logic [CNT_W-1:0]   ratio_o
);
  import wdiv_pkg::*;

  localparam logic [CNT_W-1:0] LAST = CNT_W'(TERM - 1);
  localparam logic [CNT_W-1:0] TOP  = CNT_W'(TERM);

  div_phase_e       phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] start_q, start_d;
  logic             pulse_q, pulse_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    start_d = start_q;
    pulse_d = 1'b0;
    if (phase_q == PH_PRIME) begin
      cnt_d   = CNT_W'(start_i);
      start_d = CNT_W'(start_i);
      phase_d = PH_RUN;
    end else if (fall_i) begin
      if (cnt_q == LAST) begin
        cnt_d   = CNT_W'(start_i);
        start_d = CNT_W'(start_i);
        pulse_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_PRIME;
      cnt_q   <= '0;
      start_q <= '0;
      pulse_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      start_q <= start_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse_o = pulse_q;
  assign ratio_o = TOP - start_q;

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RUN) |-> (cnt_q >= start_q && cnt_q <= LAST)); // R3
  AST_RELOAD_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> (cnt_q == start_q)); // R3
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q); // R4
  AST_START_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RUN && !fall_i) |=> $stable(start_q)); // R5
  AST_RATIO_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RUN) |-> (ratio_o >= CNT_W'(1) && ratio_o <= TOP)); // R1
endmodule

// File: rtl/mhz_step_divider.sv
module mhz_step_divider #(
  parameter int SET_W    = wdiv_pkg::SET_W_DEF,
  parameter int MOD_BASE = wdiv_pkg::MOD_BASE_DEF,
  parameter int TERM     = wdiv_pkg::TERM_DEF,
  localparam int REM_W   = $clog2(MOD_BASE),
  localparam int CNT_W   = $clog2(TERM + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] step_set,
  input  logic             pulse_in,
  output logic             div_pulse,
  output logic [CNT_W-1:0] div_ratio
);
  logic rst_meta_q, rst_sync_q;
  logic fall;
  logic [REM_W-1:0] rem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  wdiv_edge_sync u_edge (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .async_i (pulse_in),
    .fall_o  (fall)
  );

  wdiv_mod_reduce #(
    .SET_W    (SET_W),
    .MOD_BASE (MOD_BASE),
    .REM_W    (REM_W)
  ) u_mod (
    .set_i (step_set),
    .rem_o (rem)
  );

  wdiv_counter #(
    .TERM    (TERM),
    .START_W (REM_W),
    .CNT_W   (CNT_W)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .start_i (rem),
    .fall_i  (fall),
    .pulse_o (div_pulse),
    .ratio_o (div_ratio)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_sync_q |-> !div_pulse); // R6
endmodule

// File: tb/mhz_step_divider_tb.sv
`timescale 1ns/1ps
module mhz_step_divider_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] step_set = '0;
  logic       pulse_in = 1'b1;
  logic       div_pulse;
  logic [5:0] div_ratio;

  int total = 0;
  int bad   = 0;
  int pulses = 0;
  logic prev_pulse = 1'b0;

  always #4 clk = ~clk;

  mhz_step_divider dut_i (
    .clk(clk), .rst_n(rst_n), .step_set(step_set),
    .pulse_in(pulse_in), .div_pulse(div_pulse), .div_ratio(div_ratio)
  );

  always @(negedge clk) begin
    if (div_pulse) pulses++;
    if (div_pulse && prev_pulse) begin
      bad++;
      $display("FAIL R4 pulse wider than one cycle: actual=2+ expected=1");
    end
    prev_pulse <= div_pulse;
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input int s);
    @(negedge clk);
    rst_n = 1'b0;
    pulse_in = 1'b1;
    step_set = 10'(s);
    repeat (3) @(negedge clk);
    check("R6 pulse low in reset", int'(div_pulse), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    pulses = 0;
  endtask

  task automatic one_fall();
    @(negedge clk);
    pulse_in = 1'b0;
    repeat (4) @(negedge clk);
    pulse_in = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_period(input string tag, input int ratio);
    int base;
    base = pulses;
    for (int i = 1; i <= ratio; i++) begin
      one_fall();
      if (i == ratio - 1) check({tag, " no early pulse"}, pulses - base, 0);
    end
    check({tag, " pulse after ratio edges"}, pulses - base, 1);
  endtask

  task automatic t_reset_state();
    do_reset(333);
    check("R6 no pulse after release", pulses, 0);
    check("R1 ratio for S=333", int'(div_ratio), 34);
    run_period("R6 first period S=333", 34);
    run_period("R3 second period S=333", 34);
  endtask

  task automatic t_ratio_ends();
    do_reset(0);
    check("R1 ratio S=0", int'(div_ratio), 47);
    run_period("R3 S=0", 47);
    do_reset(39);
    check("R1 ratio S=39", int'(div_ratio), 8);
    run_period("R3 S=39", 8);
  endtask

  task automatic t_wrap();
    do_reset(53);
    check("R7 S=53 ratio", int'(div_ratio), 34);
    do_reset(999);
    check("R7 S=999 ratio", int'(div_ratio), 8);
    run_period("R7 S=999", 8);
    do_reset(1023);
    check("R7 S=1023 ratio", int'(div_ratio), 24);
    run_period("R7 S=1023", 24);
    do_reset(80);
    check("R7 S=80 ratio", int'(div_ratio), 47);
  endtask

  task automatic t_mid_change();
    int base;
    do_reset(333);
    base = pulses;
    for (int i = 0; i < 10; i++) one_fall();
    step_set = 10'd5;
    repeat (3) @(negedge clk);
    check("R5 ratio held after change", int'(div_ratio), 34);
    for (int i = 0; i < 23; i++) one_fall();
    check("R5 old period not cut", pulses - base, 0);
    one_fall();
    check("R5 old period ends at 34", pulses - base, 1);
    check("R5 new ratio after reload", int'(div_ratio), 42);
    run_period("R5 new period S=5", 42);
  endtask

  task automatic t_levels();
    int base;
    do_reset(79);
    base = pulses;
    for (int i = 0; i < 7; i++) one_fall();
    repeat (40) @(negedge clk);
    check("R2 steady high no count", pulses - base, 0);
    pulse_in = 1'b0;
    repeat (40) @(negedge clk);
    check("R2 steady low counts once", pulses - base, 1);
    pulse_in = 1'b1;
    repeat (10) @(negedge clk);
    check("R2 rising edge no count", pulses - base, 1);
    run_period("R2 following period", 8);
  endtask

  task automatic t_reset_mid();
    do_reset(0);
    for (int i = 0; i < 20; i++) one_fall();
    do_reset(79);
    check("R6 ratio after mid reset", int'(div_ratio), 8);
    run_period("R6 period after mid reset", 8);
  endtask

  initial begin
    t_reset_state();
    t_ratio_ends();
    t_wrap();
    t_mid_change();
    t_levels();
    t_reset_mid();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1200000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule